// File: doc/BRIEF.md
# Two-Thread Partitioned Buffer Allocator

This block hands out back-end buffer entries to micro-ops coming from two per-thread micro-op queues. Three buffers are managed: a reorder buffer, a load buffer and a store buffer. Each micro-op at a queue head states which of the three buffers it needs. In a given cycle the block serves at most one thread. It grants that thread's head micro-op its entries, pops the queue and reports an entry index for every buffer it took. Downstream logic returns entries as one-entry free pulses per thread and per buffer.

While both threads run, every thread is capped at half of each buffer. This way neither thread can starve or deadlock the other. When both threads can proceed, the block serves them in strict turn. A stalled or halted thread loses its turn, and the other thread is served every cycle. When exactly one thread is halted, the block runs in single-task mode and the running thread may fill a whole buffer. When the halt is lifted, the half caps apply again to new grants only. Entries already held beyond the cap stay held until they are freed.

Top module: `dual_thread_allocator`

## Requirements
- R1: After reset all occupancy is zero, every entry index is zero, no grant is issued without a request, and the first cycle in which both threads can be served goes to thread 0.
- R2: A thread is served only if every buffer its head micro-op needs (need bit 0 reorder, bit 1 load, bit 2 store) has room for it. Room means the thread's own cap is not reached and the buffer is not full in total. A thread without room is not served that cycle.
- R3: At most one grant is issued per cycle. `pop` has the bit of the granted thread set (bit 0 thread 0, bit 1 thread 1) in the same cycle as `grant_valid`, and is zero otherwise.
- R4: When both threads can be served, the thread served is the one not served at the previous grant, so grants alternate cycle by cycle.
- R5: A thread whose stall or halt flag is set is never served. Whenever exactly one thread can be served, it is served that cycle.
- R6: In multi-task mode (both halt flags equal), a thread receives no entry of a buffer once it holds floor(depth/2) entries of it.
- R7: In single-task mode (exactly one halt flag set), the running thread may be granted entries until the buffer holds depth entries in total.
- R8: A free pulse returns one entry of that thread and buffer. A free and a grant on the same thread and buffer in one cycle leave its occupancy unchanged.
- R9: On leaving single-task mode, entries held beyond the half cap are kept. That thread gets no new entry of the buffer until frees bring it below the cap.
- R10: Each buffer keeps one allocation index. The index is reported for the grant that takes an entry, advances by one after such a grant, wraps from depth-1 to 0, and is unchanged by grants that do not use that buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | 2 | Queue head holds a micro-op, bit per thread |
| t0_need | input | 3 | Thread 0 head needs: bit 0 reorder, bit 1 load, bit 2 store |
| t1_need | input | 3 | Thread 1 head needs, same bit order |
| stall | input | 2 | Thread stalled, bit per thread |
| halt | input | 2 | Thread halted, bit per thread |
| t0_free | input | 3 | Thread 0 returns one entry per set bit, same bit order |
| t1_free | input | 3 | Thread 1 returns one entry per set bit, same bit order |
| grant_valid | output | 1 | A micro-op is granted this cycle |
| grant_tid | output | 1 | Thread served |
| pop | output | 2 | Pop strobe for each thread's queue |
| rob_idx | output | $clog2(ROB_ENTRIES) | Reorder entry index of this grant |
| ld_idx | output | $clog2(LD_ENTRIES) | Load entry index of this grant |
| st_idx | output | $clog2(ST_ENTRIES) | Store entry index of this grant |

## Verification
The hardest state to reach from the ports is a thread holding more than half of a buffer while both threads run. It only comes about by filling a buffer during single-task mode and then lifting the halt. The bench halts thread 1 and fills the reorder buffer entirely from thread 0. It then lifts the halt while both threads keep requesting and thread 0 frees one entry per cycle. This shows when each thread regains access as occupancy drains. A long pseudo-random sweep over a small configuration then mixes stalls, halts, frees and need patterns against an arithmetic model.

// File: rtl/dta_pkg.sv
// Package: shared constants for the two-thread buffer allocator.
// Assumes exactly two threads and three buffer kinds in a fixed bit order.
package dta_pkg;
    localparam int NTHR     = 2;
    localparam int NBUF     = 3;
    localparam int BUF_ROB  = 0;
    localparam int BUF_LD   = 1;
    localparam int BUF_ST   = 2;
endpackage

// File: rtl/pool_ledger.sv
// Module: pool_ledger
// Tracks how many entries of one buffer each thread holds, tells whether each
// thread may take one more entry under the current mode, and keeps the rolling
// allocation index. Assumes at most one take per cycle and that a free pulse
// never arrives for a thread holding no entry. DEPTH must be at least 2.
module pool_ledger #(
    parameter int DEPTH = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       single_mode,
    input  logic                       take,
    input  logic                       take_tid,
    input  logic [1:0]                 free_t,
    output logic [1:0]                 fits,
    output logic [$clog2(DEPTH)-1:0]   idx
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int IW   = $clog2(DEPTH);
    localparam int HALF = DEPTH / 2;
    localparam logic [CW-1:0] LIM_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LIM_HALF = CW'(HALF);
    localparam logic [CW:0]   TOTAL_V  = (CW+1)'(DEPTH);
    localparam logic [IW-1:0] PTR_LAST = IW'(DEPTH - 1);

    logic [CW-1:0] occ [2];
    logic [CW:0]   total;
    logic [CW-1:0] lim;
    logic [IW-1:0] ptr;

    // Combined occupancy and per-thread cap for the current mode.
    always_comb begin
        total = {1'b0, occ[0]} + {1'b0, occ[1]};
        lim   = single_mode ? LIM_FULL : LIM_HALF;
    end

    genvar t;
    generate
        for (t = 0; t < 2; t++) begin : g_thr
            logic inc;
            assign inc     = take && (take_tid == 1'(t));
            assign fits[t] = (occ[t] < lim) && (total < TOTAL_V);

            // Occupancy counter: net of one take and one free per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) occ[t] <= '0;
                else        occ[t] <= occ[t] + CW'(inc) - CW'(free_t[t]);
            end

            // A free must have something to return.
            p_free_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
                free_t[t] |-> (occ[t] != '0));
        end
    endgenerate

    // Rolling allocation index, advanced by each take of this buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (take) ptr <= (ptr == PTR_LAST) ? '0 : ptr + IW'(1);
    end

    assign idx = ptr;

    // R2: a take only happens for a thread that has room.
    p_take_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> fits[take_tid]);
    // R6: in multi-task mode a taking thread is under half.
    p_mt_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !single_mode) |-> (occ[take_tid] < LIM_HALF));
    // R7: the buffer never holds more than its depth.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        total <= TOTAL_V);
endmodule

// File: rtl/thread_picker.sv
// Module: thread_picker
// Chooses which eligible thread is served this cycle. With both eligible it
// serves the one not served at the last grant; with one eligible it serves it.
// Assumes eligibility already folds in stall, halt and buffer room.
module thread_picker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig,
    output logic       grant_valid,
    output logic       grant_tid,
    output logic [1:0] pop
);
    logic turn;
    logic past_ok;

    // Selection: turn decides ties, otherwise the only eligible thread wins.
    always_comb begin
        grant_valid = |elig;
        grant_tid   = (elig == 2'b11) ? turn : elig[1];
        pop         = grant_valid ? (grant_tid ? 2'b10 : 2'b01) : 2'b00;
    end

    // Turn hand-off: after any grant, priority passes to the other thread.
    always_ff @(posedge clk) begin
        if (!rst_n)           turn <= 1'b0;
        else if (grant_valid) turn <= ~grant_tid;
    end

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: never two pops.
    p_pop_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
    // R4: with both eligible, the grant differs from the last one.
    p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && elig == 2'b11 && $past(grant_valid)) |-> (grant_tid != $past(grant_tid)));
    // R5: an eligible thread never waits on an empty cycle.
    p_serve_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != 2'b00) |-> (pop != 2'b00));
endmodule

// File: rtl/dual_thread_allocator.sv
// Module: dual_thread_allocator
// Grants reorder, load and store entries to the head micro-op of one of two
// thread queues per cycle. Multi-task mode caps each thread at half of every
// buffer; single-task mode (exactly one thread halted) lifts the cap.
// Assumes frees never exceed what a thread holds.
module dual_thread_allocator
    import dta_pkg::*;
#(
    parameter int ROB_ENTRIES = 126,
    parameter int LD_ENTRIES  = 48,
    parameter int ST_ENTRIES  = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [1:0]                       q_valid,
    input  logic [2:0]                       t0_need,
    input  logic [2:0]                       t1_need,
    input  logic [1:0]                       stall,
    input  logic [1:0]                       halt,
    input  logic [2:0]                       t0_free,
    input  logic [2:0]                       t1_free,
    output logic                             grant_valid,
    output logic                             grant_tid,
    output logic [1:0]                       pop,
    output logic [$clog2(ROB_ENTRIES)-1:0]   rob_idx,
    output logic [$clog2(LD_ENTRIES)-1:0]    ld_idx,
    output logic [$clog2(ST_ENTRIES)-1:0]    st_idx
);
    logic       single_mode;
    logic [1:0] fits_all [NBUF];
    logic [1:0] buf_ok;
    logic [1:0] elig;
    logic [2:0] grant_need;

    assign single_mode = halt[0] ^ halt[1];

    // Eligibility: queued, running, and room in every needed buffer.
    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            buf_ok[t] = 1'b1;
            for (int b = 0; b < NBUF; b++) begin
                if ((t == 0 ? t0_need[b] : t1_need[b]) && !fits_all[b][t])
                    buf_ok[t] = 1'b0;
            end
            elig[t] = q_valid[t] && !stall[t] && !halt[t] && buf_ok[t];
        end
    end

    thread_picker i_picker (
        .clk         (clk),
        .rst_n       (rst_n),
        .elig        (elig),
        .grant_valid (grant_valid),
        .grant_tid   (grant_tid),
        .pop         (pop)
    );

    assign grant_need = grant_tid ? t1_need : t0_need;

    genvar b;
    generate
        for (b = 0; b < NBUF; b++) begin : g_buf
            localparam int D  = (b == BUF_ROB) ? ROB_ENTRIES :
                                (b == BUF_LD)  ? LD_ENTRIES  : ST_ENTRIES;
            localparam int IW = $clog2(D);
            logic [IW-1:0] idx_b;

            pool_ledger #(.DEPTH(D)) i_ledger (
                .clk         (clk),
                .rst_n       (rst_n),
                .single_mode (single_mode),
                .take        (grant_valid && grant_need[b]),
                .take_tid    (grant_tid),
                .free_t      ({t1_free[b], t0_free[b]}),
                .fits        (fits_all[b]),
                .idx         (idx_b)
            );

            if (b == BUF_ROB)     begin : g_rob assign rob_idx = idx_b; end
            else if (b == BUF_LD) begin : g_ld  assign ld_idx  = idx_b; end
            else                  begin : g_st  assign st_idx  = idx_b; end
        end
    endgenerate

    // R5: a stalled or halted thread is never granted.
    p_no_blocked_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (!stall[grant_tid] && !halt[grant_tid]));
    // R3: a grant always pops the queue it served.
    p_pop_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (pop == (grant_tid ? 2'b10 : 2'b01)));
endmodule

// File: tb/test_dual_thread_allocator.sv
// Bench: drives a small allocator (depths 6/4/2) through directed phases and
// a pseudo-random sweep, checking every cycle against an arithmetic model.
module test_dual_thread_allocator;
    localparam int PER = 10;
    localparam int DV [3] = '{6, 4, 2};

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] q_valid, stall, halt;
    logic [2:0] t0_need, t1_need, t0_free, t1_free;
    logic       grant_valid, grant_tid;
    logic [1:0] pop;
    logic [2:0] rob_idx;
    logic [1:0] ld_idx;
    logic [0:0] st_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int occ [2][3];
    int ptr [3];
    bit turn;
    logic [31:0] lf = 32'h1234_5678;

    always #(PER/2) clk = ~clk;

    dual_thread_allocator #(.ROB_ENTRIES(6), .LD_ENTRIES(4), .ST_ENTRIES(2)) i_dual_thread_allocator (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .t0_need(t0_need), .t1_need(t1_need),
        .stall(stall), .halt(halt), .t0_free(t0_free), .t1_free(t1_free),
        .grant_valid(grant_valid), .grant_tid(grant_tid), .pop(pop),
        .rob_idx(rob_idx), .ld_idx(ld_idx), .st_idx(st_idx));

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: mask frees, predict, compare, then advance the model.
    task automatic tick(input string req);
        bit st, ev, et;
        bit [1:0] e;
        logic [2:0] nd [2];
        logic [2:0] fr [2];
        int act_idx, lim;
        for (int b = 0; b < 3; b++) begin
            if (t0_free[b] && occ[0][b] == 0) t0_free[b] = 1'b0;
            if (t1_free[b] && occ[1][b] == 0) t1_free[b] = 1'b0;
        end
        nd[0] = t0_need; nd[1] = t1_need;
        fr[0] = t0_free; fr[1] = t1_free;
        st = halt[0] ^ halt[1];
        for (int t = 0; t < 2; t++) begin
            e[t] = q_valid[t] && !stall[t] && !halt[t];
            for (int b = 0; b < 3; b++) begin
                lim = st ? DV[b] : DV[b] / 2;
                if (nd[t][b] && !(occ[t][b] < lim && occ[0][b] + occ[1][b] < DV[b])) e[t] = 1'b0;
            end
        end
        ev = (e != 2'b00);
        et = (e == 2'b11) ? turn : e[1];
        #1;
        cmp(req, "grant_valid", int'(grant_valid), int'(ev));
        cmp(req, "pop", int'(pop), ev ? (et ? 2 : 1) : 0);
        if (ev) begin
            cmp(req, "grant_tid", int'(grant_tid), int'(et));
            for (int b = 0; b < 3; b++) begin
                if (nd[et][b]) begin
                    act_idx = (b == 0) ? int'(rob_idx) : (b == 1) ? int'(ld_idx) : int'(st_idx);
                    cmp(req, "idx", act_idx, ptr[b]);
                end
            end
        end
        @(posedge clk);
        for (int b = 0; b < 3; b++) begin
            if (ev && nd[et][b]) begin
                occ[et][b]++;
                ptr[b] = (ptr[b] == DV[b] - 1) ? 0 : ptr[b] + 1;
            end
            for (int t = 0; t < 2; t++) if (fr[t][b]) occ[t][b]--;
        end
        if (ev) turn = ~et;
        @(negedge clk);
    endtask

    task automatic idle();
        q_valid = 2'b00; t0_need = 3'b000; t1_need = 3'b000;
        stall = 2'b00; halt = 2'b00; t0_free = 3'b000; t1_free = 3'b000;
    endtask

    // Return every held entry (R8 frees).
    task automatic drain();
        idle();
        for (int i = 0; i < 8; i++) begin
            t0_free = 3'b111; t1_free = 3'b111;
            tick("R8");
        end
        idle();
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        for (int t = 0; t < 2; t++) for (int b = 0; b < 3; b++) occ[t][b] = 0;
        for (int b = 0; b < 3; b++) ptr[b] = 0;
        turn = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: no request, no grant; then thread 0 wins the first tie.
        tick("R1");
        q_valid = 2'b11; t0_need = 3'b001; t1_need = 3'b001;
        tick("R1");
        cmp("R1", "rob_idx_after_first", int'(rob_idx), 1);

        // R4: strict alternation with no buffer needs.
        t0_need = 3'b000; t1_need = 3'b000;
        for (int i = 0; i < 6; i++) tick("R4");

        // R5: stalled and halted threads are skipped.
        stall = 2'b10;
        for (int i = 0; i < 4; i++) tick("R5");
        stall = 2'b00; halt = 2'b01;
        for (int i = 0; i < 4; i++) tick("R5");
        halt = 2'b00;

        // R8: grant and free together on one thread.
        q_valid = 2'b01; t0_need = 3'b001; t0_free = 3'b001;
        for (int i = 0; i < 5; i++) tick("R8");
        drain();

        // R6: multi-task half caps, reorder then store.
        q_valid = 2'b01; t0_need = 3'b001;
        for (int i = 0; i < 5; i++) tick("R6");
        q_valid = 2'b10; t1_need = 3'b100;
        for (int i = 0; i < 3; i++) tick("R6");
        // R2: combined need blocked by the full store share.
        t1_need = 3'b101;
        for (int i = 0; i < 2; i++) tick("R2");
        drain();

        // R7: single-task mode fills the whole reorder buffer.
        halt = 2'b10; q_valid = 2'b01; t0_need = 3'b001;
        for (int i = 0; i < 8; i++) tick("R7");

        // R9: halt lifted while over the cap; entries drain one per cycle.
        halt = 2'b00; q_valid = 2'b11; t1_need = 3'b001;
        for (int i = 0; i < 8; i++) begin
            t0_free = 3'b001;
            tick("R9");
        end
        drain();

        // R10: load index wraps at its depth.
        q_valid = 2'b10; t1_need = 3'b010;
        for (int i = 0; i < 10; i++) begin
            t1_free = 3'b010;
            tick("R10");
        end
        drain();

        // R2: pseudo-random sweep of all inputs.
        for (int i = 0; i < 3000; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            q_valid = lf[1:0];
            t0_need = lf[4:2]; t1_need = lf[7:5];
            stall   = {lf[10:8] == 3'b000, lf[13:11] == 3'b000};
            halt    = {lf[17:14] == 4'b0000, lf[21:18] == 4'b0000};
            t0_free = lf[24:22] & {3{lf[25]}};
            t1_free = lf[28:26] & {3{lf[29]}};
            tick("R2");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule